// File: doc/BRIEF.md
# UART Receiver with Fill-Level Interrupts and Address Filtering

This block is the receive half of an asynchronous serial port. It watches a single serial line, qualifies the start of each frame, and recovers every data bit by voting over three samples taken near the bit's centre. The line is sampled on a qualifying pulse that arrives at sixteen times the baud rate. Each recovered character moves into a four-entry first-word-fall-through queue, which a consumer reads through a simple pop port. A framing-error flag travels with each character.

An interrupt pulse fires according to a two-bit mode. It can fire for every stored character, when the queue reaches three entries, or when it reaches four. In nine-bit mode an address filter can be switched on, and it then drops every character whose ninth bit is clear. Software can switch the filter off once an address character has arrived, so that the data characters after it are accepted. A sticky overrun flag records a character lost because the queue was full.

Top module: `uart_rx_top`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `dataAvail`, `overrun` and `irqPulse` are 0 and `rxIdle` is 1.
- R2: A frame is one low start bit, then 8 data bits (`nineBit`=0) or 9 data bits (`nineBit`=1) sent LSB first, then one stop bit. The stored character appears on `rdData`. In 8-bit mode `rdData[8]` is 0.
- R3: A low level on the line that is gone by the middle of the start bit (8 sample ticks after detection) is dropped. The receiver goes back to idle and stores no character.
- R4: Each data bit and the stop bit take the majority of three samples at ticks 14, 15 and 16 after the previous bit centre. A single flipped sample among the three has no effect on the stored value.
- R5: The queue holds up to 4 characters in arrival order. `rdData`/`rdFrameErr` show the oldest entry and `rdEn` removes it. `dataAvail` is 1 exactly when the queue is not empty. `rdEn` on an empty queue changes nothing.
- R6: A character that completes while the queue is full is discarded and sets `overrun`. The flag stays 1 until a cycle with `clrOverrun`=1.
- R7: A stop bit voted as 0 stores the character with `rdFrameErr`=1. A voted stop of 1 gives `rdFrameErr`=0.
- R8: `irqPulse` is a one-cycle pulse when a character is stored. With `intMode`=00 or 01 it fires for every stored character. With 10 it fires only when the store brings the queue to 3 entries, and with 11 only when it brings the queue to 4. Discarded characters never fire it.
- R9: With `nineBit`=1 and `addrDetect`=1, a character whose ninth bit is 0 is dropped without setting `overrun`, and one whose ninth bit is 1 is stored. After `addrDetect` is cleared, ninth-bit-0 characters are stored again.
- R10: With `nineBit`=0, `addrDetect` has no effect: every 8-bit character is stored.
- R11: `rxIdle` is 0 from start detection until the stop-bit vote, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Serial line, idle high |
| sampleTick | input | 1 | One-cycle enable at 16 times the baud rate |
| nineBit | input | 1 | 1 selects nine data bits per frame |
| addrDetect | input | 1 | Enables the ninth-bit address filter |
| intMode | input | 2 | Interrupt fill-level mode |
| rdEn | input | 1 | Removes the head character |
| clrOverrun | input | 1 | Clears the overrun flag |
| rdData | output | 9 | Head character |
| rdFrameErr | output | 1 | Framing error of the head character |
| dataAvail | output | 1 | Queue holds at least one character |
| overrun | output | 1 | Sticky lost-character flag |
| rxIdle | output | 1 | No frame in reception |
| irqPulse | output | 1 | Fill-level interrupt pulse |

## Verification
The assertions assume that `rstN` is held low for at least two clock edges. They also assume that `nineBit`, `addrDetect` and `intMode` change only between frames, because the frame width is latched at the start bit and the filter is applied at the stop-bit vote. The stimulus changes those controls only while the line has been high long enough for the receiver to be idle. It pulses `rdEn` and `clrOverrun` only after a frame has completed. Frame lengths stay at whole multiples of the tick period. The glitch cases run with a tick on every clock, so that the flipped sample falls on a known slot.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 9;

  // strobes from the control sequencer to the datapath
  typedef struct packed {
    logic sampleBit;  // shift current line sample into the vote window
    logic takeBit;    // third vote sample: commit a data bit
    logic frameDone;  // third vote sample of the stop bit
    logic wide;       // frame carries nine data bits
  } rxStrobes_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxSync,
  input  logic       nineBit,
  output rxStrobes_t strobes,
  output logic       rxIdle
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] MID_C  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] V0_C   = CW'(OVERSAMPLE - 3);
  localparam logic [CW-1:0] V1_C   = CW'(OVERSAMPLE - 2);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rxState_t;

  rxState_t      state;
  logic [CW-1:0] tickCnt;
  logic [3:0]    bitCnt;
  logic          wideQ;
  logic [3:0]    lastBit;
  logic [CW-1:0] tickNext;

  assign lastBit  = wideQ ? 4'd8 : 4'd7;
  assign tickNext = (tickCnt == LAST_C) ? '0 : tickCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      wideQ   <= 1'b0;
    end else if (sampleTick) begin
      unique case (state)
        S_IDLE: begin
          if (!rxSync) begin
            state   <= S_START;
            tickCnt <= '0;
          end
        end
        S_START: begin
          if (tickCnt == MID_C) begin
            tickCnt <= '0;
            if (!rxSync) begin
              state  <= S_DATA;
              bitCnt <= '0;
              wideQ  <= nineBit;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            tickCnt <= tickNext;
          end
        end
        S_DATA: begin
          tickCnt <= tickNext;
          if (tickCnt == LAST_C) begin
            if (bitCnt == lastBit) state <= S_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        S_STOP: begin
          tickCnt <= tickNext;
          if (tickCnt == LAST_C) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic inBit;
  assign inBit = (state == S_DATA) || (state == S_STOP);

  always_comb begin
    strobes.sampleBit = sampleTick && inBit && ((tickCnt == V0_C) || (tickCnt == V1_C));
    strobes.takeBit   = sampleTick && (state == S_DATA) && (tickCnt == LAST_C);
    strobes.frameDone = sampleTick && (state == S_STOP) && (tickCnt == LAST_C);
    strobes.wide      = wideQ;
  end

  assign rxIdle = (state == S_IDLE);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  assign full   = (count == CNT_FULL);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      unique case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  rxStrobes_t        strobes,
  input  logic              addrDetect,
  input  logic [1:0]        intMode,
  input  logic              rdEn,
  input  logic              clrOverrun,
  output logic              rxSync,
  output logic [CHAR_W-1:0] rdData,
  output logic              rdFrameErr,
  output logic              dataAvail,
  output logic              overrun,
  output logic              irqPulse
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] CNT_TO_3Q  = CNTW'(DEPTH - 2);
  localparam logic [CNTW-1:0] CNT_TO_ALL = CNTW'(DEPTH - 1);

  // two-flop synchroniser, idle high
  logic [1:0] syncQ;
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxIn};
  end
  assign rxSync = syncQ[1];

  // three-sample majority vote
  logic [1:0] voteWin;
  logic       voted;
  always_ff @(posedge clk) begin
    if (!rstN)                  voteWin <= 2'b11;
    else if (strobes.sampleBit) voteWin <= {voteWin[0], rxSync};
  end
  assign voted = (voteWin[1] & voteWin[0]) | (voteWin[1] & rxSync) | (voteWin[0] & rxSync);

  // shift register, LSB arrives first
  logic [CHAR_W-1:0] shiftReg;
  logic [CHAR_W-1:0] frameChar;
  always_ff @(posedge clk) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobes.takeBit) shiftReg <= {voted, shiftReg[CHAR_W-1:1]};
  end
  assign frameChar = strobes.wide ? shiftReg : {1'b0, shiftReg[CHAR_W-1:1]};

  // address filter and queue entry
  logic            accept, pushEn, ovrSet, fillHit;
  logic            qFull, qEmpty;
  logic [CNTW-1:0] qCount;
  logic [CHAR_W:0] qHead;

  assign accept = strobes.frameDone && !(strobes.wide && addrDetect && !frameChar[CHAR_W-1]);
  assign pushEn = accept && !qFull;
  assign ovrSet = accept && qFull;

  uart_rx_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W + 1)) u_fifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (pushEn),
    .din   ({~voted, frameChar}),
    .pop   (rdEn),
    .dout  (qHead),
    .count (qCount),
    .full  (qFull),
    .empty (qEmpty)
  );

  assign rdData     = qHead[CHAR_W-1:0];
  assign rdFrameErr = qHead[CHAR_W];
  assign dataAvail  = !qEmpty;

  // fill-level selection, evaluated against the count before the store
  always_comb begin
    unique case (intMode)
      2'b10:   fillHit = (qCount == CNT_TO_3Q);
      2'b11:   fillHit = (qCount == CNT_TO_ALL);
      default: fillHit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      irqPulse <= pushEn && fillHit;
      if (ovrSet)          overrun <= 1'b1;
      else if (clrOverrun) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DEPTH      = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  input  logic       sampleTick,
  input  logic       nineBit,
  input  logic       addrDetect,
  input  logic [1:0] intMode,
  input  logic       rdEn,
  input  logic       clrOverrun,
  output logic [8:0] rdData,
  output logic       rdFrameErr,
  output logic       dataAvail,
  output logic       overrun,
  output logic       rxIdle,
  output logic       irqPulse
);
  rxStrobes_t strobes;
  logic       rxSync;

  uart_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .rxSync     (rxSync),
    .nineBit    (nineBit),
    .strobes    (strobes),
    .rxIdle     (rxIdle)
  );

  uart_rx_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .rxIn       (rxIn),
    .strobes    (strobes),
    .addrDetect (addrDetect),
    .intMode    (intMode),
    .rdEn       (rdEn),
    .clrOverrun (clrOverrun),
    .rxSync     (rxSync),
    .rdData     (rdData),
    .rdFrameErr (rdFrameErr),
    .dataAvail  (dataAvail),
    .overrun    (overrun),
    .irqPulse   (irqPulse)
  );
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker (
  input logic clk,
  input logic rstN,
  input logic rdEn,
  input logic clrOverrun,
  input logic dataAvail,
  input logic overrun,
  input logic rxIdle,
  input logic irqPulse
);
  // R1: reset leaves the receiver idle and empty
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (!dataAvail && !overrun && rxIdle && !irqPulse));

  // R6: overrun holds until cleared
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrOverrun) |=> overrun);

  // R6: overrun can only appear at the end of a frame
  a_r6_overrun_at_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> rxIdle);

  // R8: interrupt is a single-cycle pulse
  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R8: a pulse always follows a stored character
  a_r8_irq_has_data: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> dataAvail);

  // R11: the store happens as the sequencer returns to idle
  a_r11_irq_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> rxIdle);

  // R5: an empty queue stays empty while no frame is in flight
  a_r5_no_fill_while_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!dataAvail && rxIdle) |=> !dataAvail);
endmodule

bind uart_rx_top uart_rx_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdEn       (rdEn),
  .clrOverrun (clrOverrun),
  .dataAvail  (dataAvail),
  .overrun    (overrun),
  .rxIdle     (rxIdle),
  .irqPulse   (irqPulse)
);

// File: tb/tb_uart_rx_top.sv
module tb_uart_rx_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       rstN = 1'b0, rxIn = 1'b1, nineBit = 1'b0, addrDetect = 1'b0;
  logic [1:0] intMode = 2'b00;
  logic       rdEn = 1'b0, clrOverrun = 1'b0;
  logic [8:0] rdData;
  logic       rdFrameErr, dataAvail, overrun, rxIdle, irqPulse, sampleTick;

  int div = 1;
  int tickCnt = 0;
  always @(posedge clk) tickCnt <= (tickCnt + 1 >= div) ? 0 : tickCnt + 1;
  assign sampleTick = (tickCnt == 0);

  uart_rx_top dut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .sampleTick(sampleTick),
    .nineBit(nineBit), .addrDetect(addrDetect), .intMode(intMode),
    .rdEn(rdEn), .clrOverrun(clrOverrun), .rdData(rdData),
    .rdFrameErr(rdFrameErr), .dataAvail(dataAvail), .overrun(overrun),
    .rxIdle(rxIdle), .irqPulse(irqPulse)
  );

  int nChk = 0, nFail = 0, irqSeen = 0, expIrq = 0;
  logic expOvr = 1'b0;
  logic [9:0] model[$];
  bit done = 0;

  always @(posedge clk) if (rstN && irqPulse) irqSeen++;

  task automatic chk(string req, string what, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic slots(logic v, int n);
    rxIn = v;
    repeat (n * div) @(negedge clk);
  endtask

  // expected effect of one completed frame on the bench model
  function automatic void modelFrame(logic [8:0] d, logic ferr);
    logic [8:0] c;
    c = nineBit ? d : {1'b0, d[7:0]};
    if (nineBit && addrDetect && !c[8]) return;
    if (model.size() == DEPTH) begin
      expOvr = 1'b1;
      return;
    end
    model.push_back({ferr, c});
    if (!intMode[1] || (intMode == 2'b10 && model.size() == DEPTH - 1) ||
        (intMode == 2'b11 && model.size() == DEPTH))
      expIrq++;
  endfunction

  task automatic sendFrame(logic [8:0] d, logic stopBit, int glitchBit);
    int nb;
    nb = nineBit ? 9 : 8;
    slots(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      if (i == glitchBit) begin
        slots(d[i], 7); slots(~d[i], 1); slots(d[i], 8);
      end else begin
        slots(d[i], 16);
      end
    end
    slots(stopBit, 16);
    if (!stopBit) slots(1'b1, 16);
    slots(1'b1, 4);
    modelFrame(d, !stopBit);
  endtask

  task automatic checkState(string req);
    chk(req, "dataAvail", dataAvail, model.size() != 0);
    chk(req, "overrun", overrun, expOvr);
    chk(req, "irqCount", irqSeen, expIrq);
    chk(req, "rxIdle", rxIdle, 1);
  endtask

  task automatic drain(string req);
    while (model.size() != 0) begin
      logic [9:0] e;
      e = model.pop_front();
      chk(req, "rdData", rdData, e[8:0]);
      chk(req, "rdFrameErr", rdFrameErr, e[9]);
      rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
    end
    chk(req, "dataAvail after drain", dataAvail, 0);
  endtask

  task automatic clearOvr(string req);
    clrOverrun = 1'b1; @(negedge clk); clrOverrun = 1'b0;
    expOvr = 1'b0;
    chk(req, "overrun cleared", overrun, 0);
  endtask

  initial begin
    void'($urandom(32'd7331));
    @(negedge clk);
    repeat (5) @(negedge clk);
    // R1
    chk("R1", "dataAvail", dataAvail, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "rxIdle", rxIdle, 1);
    chk("R1", "irqPulse", irqPulse, 0);
    rstN = 1'b1;
    slots(1'b1, 4);

    // R2, 8-bit and 9-bit framing
    sendFrame(9'h0A5, 1'b1, -1); checkState("R2"); drain("R2");
    nineBit = 1'b1;
    sendFrame(9'h1C3, 1'b1, -1);
    sendFrame(9'h03C, 1'b1, -1); checkState("R2"); drain("R2");
    nineBit = 1'b0;

    // R11 busy during a frame
    fork
      sendFrame(9'h0F0, 1'b1, -1);
      begin repeat (100) @(negedge clk); chk("R11", "rxIdle mid-frame", rxIdle, 0); end
    join
    checkState("R11"); drain("R11");

    // R3 short low pulse
    slots(1'b0, 4); slots(1'b1, 40);
    chk("R3", "rxIdle", rxIdle, 1);
    chk("R3", "dataAvail", dataAvail, 0);

    // R4 single-sample glitches
    sendFrame(9'h05A, 1'b1, 3);
    sendFrame(9'h081, 1'b1, 0);
    sendFrame(9'h0FF, 1'b1, 7);
    checkState("R4"); drain("R4");

    // R7 framing errors
    sendFrame(9'h033, 1'b0, -1);
    sendFrame(9'h044, 1'b1, -1);
    checkState("R7"); drain("R7");

    // R5 read on empty
    rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
    chk("R5", "dataAvail after empty read", dataAvail, 0);

    // R8 three-quarter mode
    intMode = 2'b10;
    for (int i = 0; i < 4; i++) begin
      sendFrame(9'(i * 17 + 3), 1'b1, -1); checkState("R8");
    end
    drain("R8");

    // R8 full mode, then R6 overrun
    intMode = 2'b11;
    for (int i = 0; i < 4; i++) begin
      sendFrame(9'(i * 29 + 5), 1'b1, -1); checkState("R8");
    end
    sendFrame(9'h0EE, 1'b1, -1); checkState("R6");
    slots(1'b1, 40);
    chk("R6", "overrun held", overrun, 1);
    drain("R6");
    clearOvr("R6");
    intMode = 2'b00;

    // R9 address filter
    nineBit = 1'b1; addrDetect = 1'b1;
    sendFrame(9'h055, 1'b1, -1); checkState("R9");
    sendFrame(9'h1A3, 1'b1, -1); checkState("R9");
    addrDetect = 1'b0;
    sendFrame(9'h022, 1'b1, -1); checkState("R9"); drain("R9");

    // R10 filter ignored in 8-bit mode
    nineBit = 1'b0; addrDetect = 1'b1;
    sendFrame(9'h077, 1'b1, -1);
    sendFrame(9'h100, 1'b1, -1); checkState("R10"); drain("R10");
    addrDetect = 1'b0;

    // random batches over R2/R5/R6/R7/R8/R9
    for (int b = 0; b < 10; b++) begin
      int nf;
      div        = 1 + ($urandom % 2);
      intMode    = 2'($urandom);
      nineBit    = 1'($urandom);
      addrDetect = 1'($urandom);
      slots(1'b1, 20);
      nf = 1 + ($urandom % 6);
      for (int f = 0; f < nf; f++)
        sendFrame(9'($urandom), ($urandom % 8) != 0, -1);
      checkState("R8");
      drain("R5");
      if (expOvr) clearOvr("R6");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end
endmodule